// File: doc/BRIEF.md
# Descriptor read window

This block gives a host an indirect way to read per-accelerator descriptor words held on the device. Software first writes a 6-bit accelerator select. It then writes a 31-bit byte offset. The write clears a hardware-owned valid flag, which appears as bit 31 of the status word. The block then fetches the addressed 32-bit word over a configurable number of cycles and latches it into a data register. When the word is in place it sets the flag. Software polls the flag and then takes the data word.

Descriptor storage is produced by a combinational generator driven by parameters. Indices whose populated-mask bit is clear return zero for every word, so the index map can have holes.

The controller has three states: `ST_IDLE` (after reset, no fetch yet), `ST_FETCH` (word in flight, valid low) and `ST_READY` (word latched, valid high). It has four transitions:
- IDLE→FETCH on an offset write.
- FETCH→FETCH on a further offset write, which restarts the fetch.
- FETCH→READY when the fetch timer expires with no write in that cycle.
- READY→FETCH on an offset write.

Top module: `desc_window`

## Requirements
- R1: After reset the status word, the data word and the select readback are all zero.
- R2: An offset write stores its 31 bits, which read back in status bits 30:0. Status bit 31 (valid) reads 0 in the cycle after the write.
- R3: Valid rises, and the data register takes the new word, exactly FETCH_LAT clock edges after the edge that took the offset write (default 3).
- R4: Once set, valid and the data word hold until the next offset write. Select writes do not disturb them.
- R5: An offset write during a fetch restarts it. Valid stays 0 and rises FETCH_LAT edges after the last write, with the word for the last offset.
- R6: The select is 6 bits and reads back on `sel_q`. A fetch uses the select held at its offset write, including a select written in the same cycle. Later select writes do not change the word in flight.
- R7: The word address is offset bits 30:2. Offset bits 1:0 do not affect the fetched word.
- R8: Any offset at or beyond 0x58 returns zero data with valid set.
- R9: A select whose bit in POP_MASK is clear returns zero for every word, offset 0 included. The default mask 0x2D populates indices 0, 2, 3 and 5.
- R10: For a populated index, offset 0 returns the template length 0x0058 in bits 31:16, the template major version in 15:8 (default 0x01) and the minor version in 7:0 (default 0x00).
- R11: The six words at offsets 0x04 to 0x18 hold the 24-byte name. For the words at 0x04 and 0x08 (m = 0, 1), byte lane b (bits 8b+7:8b) is 0x41 + ((index + 4m + b) mod 26). The words at 0x0C to 0x18 are zero.
- R12: Offset 0x1C returns the accelerator major version in 31:24 (0x02), the minor version in 23:16 (0x05), a 2-bit type in 15:14 (1), a 2-bit type in 13:12 (3), zero in 11:8, and the profile in 7:0 (0x7E).
- R13: Every other word below 0x58 returns {2'b00, index, 8'h00, word address × 4 in 16 bits}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr | input | 1 | Select register write strobe |
| sel_wdata | input | 6 | Accelerator select value |
| off_wr | input | 1 | Offset register write strobe; starts a fetch |
| off_wdata | input | 31 | Byte offset to fetch |
| sel_q | output | 6 | Select register readback |
| win_status | output | 32 | {valid, stored offset} |
| win_data | output | 32 | Latched descriptor word |

## Verification
The hardest situation to reach is a state change arriving while a fetch is in flight. This covers an offset rewrite that must restart the timer, and a select rewrite that must not leak into the word being fetched. The stimulus issues a second strobe one or two cycles after the first, well inside the three-cycle latency. The scoreboard then checks both the word returned and the delay measured from the last offset write. A select and an offset written in the same cycle are also driven, to show that the new select is taken.

// File: rtl/desc_win_pkg.sv
package desc_win_pkg;
    localparam int IDX_W       = 6;
    localparam int OFF_W       = 31;
    localparam int WORD_W      = 32;
    localparam int WADDR_W     = OFF_W - 2;
    localparam int TMPL_BYTES  = 'h58;
    localparam int TMPL_WORDS  = TMPL_BYTES / 4;
    localparam int NAME_FIRST  = 1;
    localparam int NAME_WORDS  = 6;
    localparam int LETTER_WDS  = 2;
    localparam int VER_WORD    = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_READY = 2'd2
    } win_state_e;
endpackage

// File: rtl/desc_rom.sv
module desc_rom
    import desc_win_pkg::*;
#(
    parameter logic [2**IDX_W-1:0] POP_MASK = 64'h2D,
    parameter logic [7:0] TMPL_MAJ = 8'h01,
    parameter logic [7:0] TMPL_MIN = 8'h00,
    parameter logic [7:0] ACC_MAJ  = 8'h02,
    parameter logic [7:0] ACC_MIN  = 8'h05,
    parameter logic [1:0] TYPE_HI  = 2'd1,
    parameter logic [1:0] TYPE_LO  = 2'd3,
    parameter logic [7:0] PROFILE  = 8'h7E
) (
    input  logic [IDX_W-1:0]   idx,
    input  logic [WADDR_W-1:0] waddr,
    output logic [WORD_W-1:0]  word
);
    logic [WORD_W-1:0] name_w [LETTER_WDS];

    for (genvar m = 0; m < LETTER_WDS; m++) begin : g_word
        for (genvar b = 0; b < 4; b++) begin : g_lane
            logic [7:0] sum;
            assign sum = {2'b00, idx} + 8'(4 * m + b);
            assign name_w[m][8*b +: 8] = 8'h41 + 8'(sum % 8'd26);
        end
    end

    always_comb begin
        word = '0;
        if (!POP_MASK[idx] || waddr >= WADDR_W'(TMPL_WORDS)) begin
            word = '0;
        end else if (waddr == '0) begin
            word = {16'(TMPL_BYTES), TMPL_MAJ, TMPL_MIN};
        end else if (waddr >= WADDR_W'(NAME_FIRST) &&
                     waddr <  WADDR_W'(NAME_FIRST + NAME_WORDS)) begin
            if (waddr == WADDR_W'(NAME_FIRST))          word = name_w[0];
            else if (waddr == WADDR_W'(NAME_FIRST + 1)) word = name_w[1];
            else                                        word = '0;
        end else if (waddr == WADDR_W'(VER_WORD)) begin
            word = {ACC_MAJ, ACC_MIN, TYPE_HI, TYPE_LO, 4'h0, PROFILE};
        end else begin
            word = {2'b00, idx, 8'h00, waddr[13:0], 2'b00};
        end
    end
endmodule

// File: rtl/fetch_timer.sv
module fetch_timer #(
    parameter int LAT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic done
);
    localparam int CW = (LAT < 2) ? 1 : $clog2(LAT + 1);
    logic [CW-1:0] cnt;

    assign done = (cnt == CW'(LAT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (start)        cnt <= '0;
        else if (run && !done) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/desc_window.sv
module desc_window
    import desc_win_pkg::*;
#(
    parameter int FETCH_LAT = 3,
    parameter logic [2**IDX_W-1:0] POP_MASK = 64'h2D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [IDX_W-1:0]  sel_wdata,
    input  logic              off_wr,
    input  logic [OFF_W-1:0]  off_wdata,
    output logic [IDX_W-1:0]  sel_q,
    output logic [WORD_W-1:0] win_status,
    output logic [WORD_W-1:0] win_data
);
    win_state_e        state, state_nxt;
    logic [IDX_W-1:0]  sel_r, fetch_idx;
    logic [OFF_W-1:0]  off_r;
    logic [WORD_W-1:0] data_r, rom_word;
    logic              tmr_done;
    logic              latch_en;

    fetch_timer #(.LAT(FETCH_LAT)) u_tmr (
        .clk  (clk),
        .rst_n(rst_n),
        .start(off_wr),
        .run  (state == ST_FETCH),
        .done (tmr_done)
    );

    desc_rom #(.POP_MASK(POP_MASK)) u_rom (
        .idx  (fetch_idx),
        .waddr(off_r[OFF_W-1:2]),
        .word (rom_word)
    );

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (off_wr) state_nxt = ST_FETCH;
            ST_FETCH: if (off_wr) state_nxt = ST_FETCH;
                      else if (tmr_done) state_nxt = ST_READY;
            ST_READY: if (off_wr) state_nxt = ST_FETCH;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    assign latch_en = (state == ST_FETCH) && tmr_done && !off_wr;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_r     <= '0;
            off_r     <= '0;
            fetch_idx <= '0;
            data_r    <= '0;
        end else begin
            if (sel_wr) sel_r <= sel_wdata;
            if (off_wr) begin
                off_r     <= off_wdata;
                fetch_idx <= sel_wr ? sel_wdata : sel_r;
            end
            if (latch_en) data_r <= rom_word;
        end
    end

    always_comb begin
        sel_q      = sel_r;
        win_status = {state == ST_READY, off_r};
        win_data   = data_r;
    end
endmodule

// File: rtl/desc_window_chk.sv
module desc_window_chk
    import desc_win_pkg::*;
#(
    parameter int FETCH_LAT = 3,
    parameter logic [2**IDX_W-1:0] POP_MASK = 64'h2D
) (
    input logic              clk,
    input logic              rst_n,
    input logic              off_wr,
    input logic [WORD_W-1:0] win_status,
    input logic [WORD_W-1:0] win_data,
    input logic [IDX_W-1:0]  fetch_idx,
    input logic [OFF_W-1:0]  fetch_off
);
    localparam int SW = $clog2(FETCH_LAT + 3);
    logic [SW-1:0] since_wr;

    always_ff @(posedge clk) begin
        if (!rst_n)              since_wr <= '0;
        else if (off_wr)         since_wr <= SW'(1);
        else if (since_wr != '1 && since_wr != '0) since_wr <= since_wr + 1'b1;
    end

    AST_VALID_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        off_wr |=> !win_status[31]); // R2
    AST_FETCH_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(win_status[31]) |-> since_wr == SW'(FETCH_LAT + 1)); // R3
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (win_status[31] && !off_wr) |=> (win_status[31] && $stable(win_data))); // R4
    AST_ZERO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(win_status[31]) && fetch_off[OFF_W-1:2] >= WADDR_W'(TMPL_WORDS)) |-> win_data == '0); // R8
    AST_UNPOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(win_status[31]) && !POP_MASK[fetch_idx]) |-> win_data == '0); // R9
endmodule

bind desc_window desc_window_chk #(.FETCH_LAT(FETCH_LAT), .POP_MASK(POP_MASK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .off_wr    (off_wr),
    .win_status(win_status),
    .win_data  (win_data),
    .fetch_idx (fetch_idx),
    .fetch_off (off_r)
);

// File: tb/test_desc_window.sv
module test_desc_window;
    localparam int LAT = 3;
    localparam logic [63:0] POP = 64'h2D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_wr = 1'b0;
    logic [5:0]  sel_wdata = '0;
    logic        off_wr = 1'b0;
    logic [30:0] off_wdata = '0;
    logic [5:0]  sel_q;
    logic [31:0] win_status, win_data;

    int total = 0;
    int fails = 0;
    int cyc = 0;
    int last_wr = 0;
    int cur_idx = 0;
    logic [31:0] exp_q[$];
    logic prev_v = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    desc_window #(.FETCH_LAT(LAT), .POP_MASK(POP)) i_desc_window (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
        .off_wr(off_wr), .off_wdata(off_wdata), .sel_q(sel_q),
        .win_status(win_status), .win_data(win_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_word(input int ix, input int off);
        int wa;
        logic [31:0] r;
        wa = off / 4;
        r = '0;
        if (!POP[ix] || wa >= 22) return '0;
        if (wa == 0) return 32'h0058_0100;
        if (wa == 1 || wa == 2) begin
            for (int b = 0; b < 4; b++)
                r[8*b +: 8] = 8'(8'h41 + (ix + 4 * (wa - 1) + b) % 26);
            return r;
        end
        if (wa >= 3 && wa <= 6) return '0;
        if (wa == 7) return {8'h02, 8'h05, 2'd1, 2'd3, 4'h0, 8'h7E};
        return {2'b00, 6'(ix), 8'h00, 16'(wa * 4)};
    endfunction

    // monitor: pops expected words when valid rises
    always @(negedge clk) begin
        if (rst_n) begin
            if (win_status[31] && !prev_v) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected completion", win_data, 32'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(win_data == e, "R3/R10-R13 data", win_data, e);
                    chk(cyc - last_wr == LAT + 1, "R3 latency", 32'(cyc - last_wr), 32'(LAT + 1));
                end
            end
            prev_v = win_status[31];
        end
    end

    task automatic wr_sel(input int ix);
        @(negedge clk);
        sel_wr = 1'b1; sel_wdata = 6'(ix);
        cur_idx = ix;
        @(negedge clk);
        sel_wr = 1'b0;
        chk(sel_q == 6'(ix), "R6 select readback", 32'(sel_q), 32'(ix));
    endtask

    task automatic wr_off(input int off, input bit push, input int also_sel);
        @(negedge clk);
        if (also_sel >= 0) begin
            sel_wr = 1'b1; sel_wdata = 6'(also_sel); cur_idx = also_sel;
        end
        off_wr = 1'b1; off_wdata = 31'(off);
        last_wr = cyc;
        if (push) exp_q.push_back(ref_word(cur_idx, off));
        @(negedge clk);
        off_wr = 1'b0; sel_wr = 1'b0;
        chk(win_status[31] == 1'b0, "R2 valid cleared", 32'(win_status[31]), 32'h0);
        chk(win_status[30:0] == 31'(off), "R2 offset readback", {1'b0, win_status[30:0]}, 32'(off));
    endtask

    task automatic drain();
        for (int i = 0; i < 40 && exp_q.size() != 0; i++) @(negedge clk);
        @(negedge clk);
        chk(exp_q.size() == 0, "R3 completion seen", 32'(exp_q.size()), 32'h0);
    endtask

    task automatic fetch(input int off);
        wr_off(off, 1'b1, -1);
        drain();
    endtask

    initial begin
        #(8 * 100000);
        chk(1'b0, "watchdog", 32'h0, 32'h0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(win_status == 0, "R1 status", win_status, 0);
        chk(win_data == 0, "R1 data", win_data, 0);
        chk(sel_q == 0, "R1 select", 32'(sel_q), 0);

        // R10, R11, R12, R13 on index 0
        fetch(0);
        for (int k = 4; k <= 'h18; k += 4) fetch(k);
        fetch('h1C);
        fetch('h20);
        // R7: low offset bits ignored
        fetch('h23);
        fetch('h54);
        // R8: out of range
        fetch('h58);
        fetch('h7FFF_FFFC);

        // R9: unpopulated index 1
        wr_sel(1);
        fetch(0);
        fetch(4);
        fetch('h1C);
        // populated index 5
        wr_sel(5);
        fetch(0);
        fetch(8);

        // R4: hold across select writes
        wr_sel(3);
        fetch('h1C);
        wr_sel(1);
        repeat (5) @(negedge clk);
        chk(win_status[31] == 1'b1, "R4 valid held", 32'(win_status[31]), 1);
        chk(win_data == ref_word(3, 'h1C), "R4 data held", win_data, ref_word(3, 'h1C));

        // R5: restart during fetch
        wr_sel(2);
        wr_off('h4, 1'b0, -1);
        wr_off('h8, 1'b1, -1);
        drain();
        wr_off('h30, 1'b0, -1);
        wr_off('h0, 1'b0, -1);
        wr_off('h1C, 1'b1, -1);
        drain();

        // R6: select written during fetch does not affect word in flight
        wr_off('h4, 1'b1, -1);
        wr_sel(1);
        drain();
        // R6: select and offset in same cycle
        wr_off('h4, 1'b1, 5);
        drain();
        wr_off('h40, 1'b1, 0);
        drain();

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule